// File: doc/BRIEF.md
# Privilege-Filtered Event Counter with Sticky Overflow

This block is one programmable hardware performance counter. Each cycle in which the `inc` pulse is high and the event qualifies, the count goes up by one. An event qualifies when the counter is not inhibited and the current privilege level is not filtered out. The block holds the filter bits and a sticky overflow flag in an internal event-flag register, which software loads through a write port. When the count wraps from all-ones to zero, the overflow flag is set and the interrupt request goes high.

The count is stored as a low half and a high half. The carry from the low half into the high half is the same in both modes. In split-halves mode, software reads and writes the value one half at a time. In this mode the event flags sit in the upper-half event word. In full-width mode the counter and the event word are each one wide access.

Top module: `hpm_counter`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `count` is zero, `ovf_flag` and `irq_req` are low, and all filter bits are clear.
- R2: Privilege encoding is 2'b11 machine, 2'b01 supervisor, 2'b00 user, and 2'b10 reserved. A cycle with `inc` high and a qualifying event raises `count` by one at the next edge. Without `inc`, or at the reserved level, `count` does not change.
- R3: While `inhibit` is high, `count` does not change through increments.
- R4: While the machine filter bit is set, increments at machine level are ignored. `virt_on` has no effect at machine level.
- R5: At supervisor level, increments are ignored when the supervisor filter bit is set and `virt_on` is low. They are also ignored when the guest-supervisor filter bit is set and `virt_on` is high.
- R6: At user level, increments are ignored when the user filter bit is set and `virt_on` is low. They are also ignored when the guest-user filter bit is set and `virt_on` is high.
- R7: A qualifying increment with the low half at all-ones carries into the high half. With both halves at all-ones, both halves wrap to zero, and that wrap is the overflow event.
- R8: An overflow sets `ovf_flag`. If the flag is already set, it stays set. Only an accepted event-flag write that carries a zero overflow bit clears it.
- R9: The event-flag word is {overflow, machine, supervisor, user, guest-supervisor, guest-user}. In full-width mode it is taken from `evt_wr_data[63:58]`. In split-halves mode it is taken from bits [31:26], and only when `evt_wr_hi` is high. A split-mode write with `evt_wr_hi` low changes nothing.
- R10: In full-width mode, `cnt_wr_en` loads all of `cnt_wr_data`. In split-halves mode, it loads `cnt_wr_data[31:0]` into the half that `cnt_wr_hi` selects and keeps the other half. A counter write in the same cycle as an increment wins, and the increment is dropped.
- R11: An accepted event-flag write in the same cycle as an overflow takes priority over the overflow.
- R12: `irq_req` is a level signal equal to `ovf_flag` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_lvl | input | 2 | Current privilege level |
| virt_on | input | 1 | Guest (virtualized) execution flag |
| inhibit | input | 1 | This counter's count-inhibit bit |
| split_mode | input | 1 | 1: split-halves access, 0: full-width access |
| inc | input | 1 | Event pulse |
| cnt_wr_en | input | 1 | Counter value write strobe |
| cnt_wr_hi | input | 1 | Split mode: write the upper half |
| cnt_wr_data | input | 64 | Counter write data |
| evt_wr_en | input | 1 | Event-flag write strobe |
| evt_wr_hi | input | 1 | Split mode: write targets the upper event word |
| evt_wr_data | input | 64 | Event-flag write data |
| count | output | 64 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_req | output | 1 | Overflow interrupt request (level) |

## Verification
The overflow wrap is the hard case. Counting up to it from reset would take 2^64 events, so the stimulus first loads values one or a few increments below all-ones. It does this through both full-width writes and split half-writes, then lets qualifying pulses run the counter over. The random phase draws its write data mostly from near-all-ones values. That way, repeated overflows with the flag already set happen often, and so do overflows that coincide with a flag write. Directed sequences cover each privilege and guest combination against its filter bit, and the split-mode lower-word event write that must be ignored.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  // per-level filter bits, packed in event-word order
  typedef struct packed {
    logic m_inh;
    logic s_inh;
    logic u_inh;
    logic vs_inh;
    logic vu_inh;
  } filt_t;

  typedef struct packed {
    logic  of;
    filt_t filt;
  } evflags_t;

  localparam int unsigned FLAG_W = $bits(evflags_t);

endpackage

// File: rtl/hpm_priv_filter.sv
module hpm_priv_filter
  import hpm_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt_on,
  input  filt_t      filt,
  input  logic       inhibit,
  input  logic       inc,
  output logic       qual
);

  logic blocked;

  always_comb begin
    case (priv_e'(priv))
      PRIV_M:  blocked = filt.m_inh;
      PRIV_S:  blocked = virt_on ? filt.vs_inh : filt.s_inh;
      PRIV_U:  blocked = virt_on ? filt.vu_inh : filt.u_inh;
      default: blocked = 1'b1;
    endcase
    qual = inc & ~inhibit & ~blocked;
  end

endmodule

// File: rtl/hpm_count_half.sv
module hpm_count_half #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         inc_en,
  output logic [W-1:0] q,
  output logic         all_ones
);

  logic [W-1:0] q_d;
  logic         upd;

  always_comb begin
    upd = wr_en | inc_en;
    q_d = wr_en ? wr_data : q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd) begin
      q <= q_d;
    end
  end

  assign all_ones = &q;

endmodule

// File: rtl/hpm_ovf_ctl.sv
module hpm_ovf_ctl
  import hpm_pkg::*;
#(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_mode,
  input  logic             evt_wr_en,
  input  logic             evt_wr_hi,
  input  logic [CNT_W-1:0] evt_wr_data,
  input  logic             ovf_evt,
  output logic             of_q,
  output filt_t            filt_q
);

  evflags_t wide_f;
  evflags_t narrow_f;
  evflags_t nxt;
  logic     accept;
  logic     upd;
  logic     evt_unused;

  assign wide_f     = evflags_t'(evt_wr_data[CNT_W-1 -: FLAG_W]);
  assign narrow_f   = evflags_t'(evt_wr_data[HALF_W-1 -: FLAG_W]);
  assign evt_unused = ^evt_wr_data;

  always_comb begin
    accept = evt_wr_en & (~split_mode | evt_wr_hi);
    if (accept) begin
      nxt = split_mode ? narrow_f : wide_f;
    end else begin
      nxt.of   = of_q | ovf_evt;
      nxt.filt = filt_q;
    end
    upd = accept | (ovf_evt & ~of_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      of_q   <= 1'b0;
      filt_q <= '0;
    end else if (upd) begin
      of_q   <= nxt.of;
      filt_q <= nxt.filt;
    end
  end

endmodule

// File: rtl/hpm_counter.sv
module hpm_counter
  import hpm_pkg::*;
#(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       priv_lvl,
  input  logic             virt_on,
  input  logic             inhibit,
  input  logic             split_mode,
  input  logic             inc,
  input  logic             cnt_wr_en,
  input  logic             cnt_wr_hi,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             evt_wr_en,
  input  logic             evt_wr_hi,
  input  logic [CNT_W-1:0] evt_wr_data,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq_req
);

  filt_t                  filt_q;
  logic                   of_q;
  logic                   qual;
  logic                   ovf_evt;
  logic [1:0]             half_we;
  logic [1:0]             half_inc;
  logic [1:0]             half_ones;
  logic [1:0][HALF_W-1:0] half_q;
  logic [1:0][HALF_W-1:0] half_wd;

  hpm_priv_filter u_filt (
    .priv    (priv_lvl),
    .virt_on (virt_on),
    .filt    (filt_q),
    .inhibit (inhibit),
    .inc     (inc),
    .qual    (qual)
  );

  always_comb begin
    half_we[0]  = cnt_wr_en & (~split_mode | ~cnt_wr_hi);
    half_we[1]  = cnt_wr_en & (~split_mode | cnt_wr_hi);
    half_wd[0]  = cnt_wr_data[HALF_W-1:0];
    half_wd[1]  = split_mode ? cnt_wr_data[HALF_W-1:0]
                             : cnt_wr_data[CNT_W-1:HALF_W];
    half_inc[0] = qual & ~cnt_wr_en;
    half_inc[1] = half_inc[0] & half_ones[0];
    ovf_evt     = half_inc[1] & half_ones[1];
  end

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      hpm_count_half #(.W(HALF_W)) u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (half_we[h]),
        .wr_data  (half_wd[h]),
        .inc_en   (half_inc[h]),
        .q        (half_q[h]),
        .all_ones (half_ones[h])
      );
    end
  endgenerate

  hpm_ovf_ctl #(.HALF_W(HALF_W)) u_ovf (
    .clk         (clk),
    .rst_n       (rst_n),
    .split_mode  (split_mode),
    .evt_wr_en   (evt_wr_en),
    .evt_wr_hi   (evt_wr_hi),
    .evt_wr_data (evt_wr_data),
    .ovf_evt     (ovf_evt),
    .of_q        (of_q),
    .filt_q      (filt_q)
  );

  assign count    = half_q;
  assign ovf_flag = of_q;
  assign irq_req  = of_q;

endmodule

// File: rtl/hpm_counter_chk.sv
module hpm_counter_chk
  import hpm_pkg::*;
#(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       priv_lvl,
  input logic             inhibit,
  input logic             split_mode,
  input logic             inc,
  input logic             cnt_wr_en,
  input logic             cnt_wr_hi,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic             evt_wr_en,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input filt_t            filt_q
);

  logic m_go;
  assign m_go = inc && !inhibit && (priv_lvl == 2'b11) && !filt_q.m_inh && !cnt_wr_en;

  assert_inhibit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !cnt_wr_en) |=> $stable(count));

  assert_rsv_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_lvl == 2'b10 && !cnt_wr_en) |=> $stable(count));

  assert_mfilter_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_lvl == 2'b11 && filt_q.m_inh && !cnt_wr_en) |=> $stable(count));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_go && !(&count)) |=> (count == $past(count) + CNT_W'(1)));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_go && (&count) && !evt_wr_en) |=> (count == '0 && ovf_flag));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !evt_wr_en) |=> ovf_flag);

  assert_of_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(evt_wr_en || (&count)));

  assert_wr_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_en && !split_mode) |=> (count == $past(cnt_wr_data)));

  assert_wr_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_en && split_mode && cnt_wr_hi) |=>
      (count[CNT_W-1:HALF_W] == $past(cnt_wr_data[HALF_W-1:0]) &&
       count[HALF_W-1:0] == $past(count[HALF_W-1:0])));

endmodule

bind hpm_counter hpm_counter_chk #(.HALF_W(HALF_W)) u_chk (.*);

// File: tb/tb_hpm_counter.sv
module tb_hpm_counter;

  logic        clk;
  logic        rst_n;
  logic [1:0]  priv_lvl;
  logic        virt_on, inhibit, split_mode, inc;
  logic        cnt_wr_en, cnt_wr_hi, evt_wr_en, evt_wr_hi;
  logic [63:0] cnt_wr_data, evt_wr_data;
  logic [63:0] count;
  logic        ovf_flag, irq_req;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  logic [63:0] m_cnt;
  logic        m_of;
  logic [4:0]  m_flt;   // {m, s, u, vs, vu}

  hpm_counter dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic blocked_f(logic [1:0] p, logic v, logic [4:0] f);
    case (p)
      2'b11:   return f[4];
      2'b01:   return v ? f[1] : f[3];
      2'b00:   return v ? f[0] : f[2];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [63:0] evt_word(logic sp, logic [5:0] fl);
    return sp ? {32'h0, fl, 26'h0} : {fl, 58'h0};
  endfunction

  task automatic compare(string tag);
    checks++;
    if (count !== m_cnt) begin
      fails++;
      $display("FAIL %s count actual=%h expected=%h", tag, count, m_cnt);
    end
    checks++;
    if (ovf_flag !== m_of) begin
      fails++;
      $display("FAIL %s ovf_flag actual=%b expected=%b", tag, ovf_flag, m_of);
    end
    checks++;
    if (irq_req !== m_of) begin
      fails++;
      $display("FAIL %s R12 irq_req actual=%b expected=%b", tag, irq_req, m_of);
    end
  endtask

  task automatic step(string tag);
    logic [63:0] n_cnt;
    logic        n_of, q, ov;
    logic [4:0]  n_flt;
    logic [5:0]  fl;
    q     = inc && !inhibit && !blocked_f(priv_lvl, virt_on, m_flt);
    n_cnt = m_cnt;
    ov    = 1'b0;
    if (cnt_wr_en) begin
      if (!split_mode)    n_cnt = cnt_wr_data;
      else if (cnt_wr_hi) n_cnt[63:32] = cnt_wr_data[31:0];
      else                n_cnt[31:0]  = cnt_wr_data[31:0];
    end else if (q) begin
      ov    = (m_cnt == '1);
      n_cnt = m_cnt + 64'd1;
    end
    n_of  = m_of | ov;
    n_flt = m_flt;
    if (evt_wr_en && (!split_mode || evt_wr_hi)) begin
      fl    = split_mode ? evt_wr_data[31:26] : evt_wr_data[63:58];
      n_of  = fl[5];
      n_flt = fl[4:0];
    end
    @(negedge clk);
    m_cnt = n_cnt;
    m_of  = n_of;
    m_flt = n_flt;
    compare(tag);
  endtask

  task automatic quiet();
    inc = 0; cnt_wr_en = 0; cnt_wr_hi = 0; evt_wr_en = 0; evt_wr_hi = 0;
    cnt_wr_data = '0; evt_wr_data = '0;
  endtask

  task automatic set_flags(logic [5:0] fl, string tag);
    quiet();
    evt_wr_en = 1; evt_wr_hi = 1; evt_wr_data = evt_word(split_mode, fl);
    step(tag);
    quiet();
  endtask

  task automatic load(logic hi, logic [63:0] d, string tag);
    quiet();
    cnt_wr_en = 1; cnt_wr_hi = hi; cnt_wr_data = d;
    step(tag);
    quiet();
  endtask

  task automatic pulses(int n, string tag);
    for (int i = 0; i < n; i++) begin
      inc = 1;
      step(tag);
    end
    inc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; priv_lvl = 2'b11; virt_on = 0; inhibit = 0; split_mode = 0;
    quiet();
    m_cnt = '0; m_of = 0; m_flt = '0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    step("R1 after release");

    // R2: basic counting, idle, reserved level
    pulses(5, "R2 machine count");
    step("R2 no pulse");
    priv_lvl = 2'b10;
    pulses(2, "R2 reserved level");
    priv_lvl = 2'b11;

    // R3: inhibit
    inhibit = 1;
    pulses(3, "R3 inhibit");
    inhibit = 0;

    // R4: machine filter, virt_on irrelevant
    set_flags(6'b010000, "R4 load filter");
    pulses(2, "R4 machine blocked");
    virt_on = 1;
    pulses(1, "R4 machine blocked virt");
    virt_on = 0; priv_lvl = 2'b01;
    pulses(1, "R4 supervisor still counts");

    // R5: supervisor filters
    set_flags(6'b001000, "R5 load filter");
    pulses(2, "R5 supervisor blocked");
    virt_on = 1;
    pulses(2, "R5 guest supervisor counts");
    set_flags(6'b000010, "R5 load guest filter");
    pulses(2, "R5 guest supervisor blocked");
    virt_on = 0;
    pulses(1, "R5 supervisor counts");

    // R6: user filters
    priv_lvl = 2'b00;
    set_flags(6'b000100, "R6 load filter");
    pulses(2, "R6 user blocked");
    virt_on = 1;
    pulses(1, "R6 guest user counts");
    set_flags(6'b000001, "R6 load guest filter");
    pulses(2, "R6 guest user blocked");
    virt_on = 0;
    pulses(1, "R6 user counts");
    priv_lvl = 2'b11;
    set_flags(6'b000000, "R9 clear filters");

    // R10: write wins over increment
    quiet(); inc = 1; cnt_wr_en = 1; cnt_wr_data = 64'h1234;
    step("R10 write beats increment");
    quiet();

    // R7 carry and wrap in split mode
    split_mode = 1;
    load(0, 64'hFFFF_FFFF, "R10 split low write");
    load(1, 64'h0, "R10 split high write");
    pulses(1, "R7 carry into high half");
    load(0, 64'hFFFF_FFFF, "R10 split low write");
    load(1, 64'hFFFF_FFFF, "R10 split high write");
    pulses(1, "R7 wrap both halves");
    pulses(1, "R7 after wrap");

    // R8 sticky with second overflow
    load(0, 64'hFFFF_FFFF, "R8 reload");
    load(1, 64'hFFFF_FFFF, "R8 reload");
    pulses(1, "R8 second overflow flag stays");

    // R9: low event word ignored in split mode, upper accepted
    quiet(); evt_wr_en = 1; evt_wr_hi = 0; evt_wr_data = 64'h0;
    step("R9 split lower word ignored");
    set_flags(6'b000000, "R8 clear via upper word");
    split_mode = 0;
    quiet(); evt_wr_en = 1; evt_wr_data = {6'b000000, 26'h0, 6'b110000, 26'h0};
    step("R9 full mode ignores bits 31:26");
    quiet();
    pulses(1, "R9 machine not filtered");

    // R11: flag write same cycle as overflow
    load(0, '1, "R11 preload");
    quiet(); inc = 1; evt_wr_en = 1; evt_wr_data = evt_word(0, 6'b000000);
    step("R11 write beats overflow");
    quiet();

    // random phase
    for (int c = 0; c < 4000; c++) begin
      string tag;
      int r;
      logic [5:0] fh, fl;
      if (c % 500 == 0) split_mode = $urandom % 2;
      quiet();
      priv_lvl = 2'($urandom);
      virt_on  = 1'($urandom);
      inhibit  = ($urandom % 8) == 0;
      inc      = ($urandom % 4) != 0;
      tag      = "R2 random";
      if ($urandom % 12 == 0) begin
        cnt_wr_en = 1; cnt_wr_hi = 1'($urandom);
        r = $urandom % 4;
        case (r)
          0: cnt_wr_data = '1;
          1: cnt_wr_data = {32'hFFFF_FFFF, 32'hFFFF_FFF0 | 32'($urandom % 16)};
          2: cnt_wr_data = {$urandom, $urandom};
          default: cnt_wr_data = 64'hFFFF_FFFF_FFFF_FFFE;
        endcase
        tag = "R10 random";
      end
      if ($urandom % 24 == 0) begin
        fh = 6'($urandom); fl = 6'($urandom);
        if ($urandom % 4 != 0) begin fh[4:0] = '0; fl[4:0] = '0; end
        evt_wr_en = 1; evt_wr_hi = 1'($urandom);
        evt_wr_data = {fh, 26'($urandom), fl, 26'($urandom)};
        tag = "R9 random";
      end
      step(tag);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule